// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Staged Settings

This block holds a parameterised number of identical pulse-width channels behind a simple 32-bit register bus. Every channel generates its period from two 16-bit counters in series. A prescaler stretches each step, and a period divider counts steps per period. A 16-bit high-count sets how many prescaled steps the output stays high at the start of each period.

Software never changes a running channel directly. It writes new prescaler, divider and high-count values into staging fields. It then sets a trigger bit in the second register of the channel. The channel moves all three values into its active counters together, at the next period boundary, and clears the trigger bit at that moment. Software can poll the bit to learn that the new settings are live. A per-channel enable bit starts and stops the output.

Channel n occupies byte offsets 8n and 8n+4. The decoder uses address bits [AW-1:3] as the channel index and bit 2 as the word select. Bits [1:0] are ignored.

Top module: `shadow_pwm_bank`

## Requirements
- R1: After reset, every register reads zero and every output is low.
- R2: Word 0 of a channel holds the period divider in bits [15:0] and the high-count in bits [31:16]. Word 1 holds the prescaler in bits [15:0], the trigger in bit 30 and the enable in bit 31. Bits [29:16] of word 1 read as zero whatever was written.
- R3: While a channel is enabled, its output repeats with a period of (prescaler+1)*(divider+1) clocks.
- R4: The output is high for the first min((high+1)*(prescaler+1), period) clocks of each period and low for the rest.
- R5: Staged writes do not change a running output. The trigger bit reads 1 from the write until the transfer happens, and reads 0 afterwards.
- R6: On an enabled channel, the transfer happens only in the last clock of a period. The period in progress finishes with the old settings, and the next period uses only the new ones.
- R7: A disabled channel drives its output low and holds its counters at zero. A trigger set while the channel is disabled is applied in the next clock.
- R8: Setting the enable starts a fresh period. The output is high in the first clock after the write.
- R9: An access whose channel index is NCH or above reads zero, and a write to it changes no channel.
- R10: Channels run independently; settings or enables of one do not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | AW | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| pwmOut | output | NCH | One pulse output per channel |

## Verification
A wrong counter or active value shows on the output within one period. It appears as a high run or a low run of the wrong length, or as a period edge in the wrong clock. A transfer taken in the middle of a period instead of at its end changes the tail of the old period at once. A trigger bit that clears too early or too late shows up in a read taken the clock after the write, or in the first period of the new settings.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;

  // Field width fixed by the register layout.
  localparam int FIELD_W = 16;

  // Control-to-datapath bundle for one channel.
  typedef struct packed {
    logic               en;
    logic               updPend;
    logic [FIELD_W-1:0] pre;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] hi;
  } chanCtl_t;

endpackage

// File: rtl/shadow_pwm_ctrl.sv
module shadow_pwm_ctrl
  import shadow_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [AW-1:0]        busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NCH-1:0]       loadAck,
  output chanCtl_t [NCH-1:0]   ctl
);

  localparam int IDX_W = AW - 3;

  logic [IDX_W-1:0] idx;
  logic             wordSel;
  logic             hit;
  logic             unusedBits;

  assign idx        = busAddr[AW-1:3];
  assign wordSel    = busAddr[2];
  assign hit        = int'(idx) < NCH;
  assign unusedBits = ^{busAddr[1:0], busWdata[29:16]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chanCtl_t r;
    logic     wr0;
    logic     wr1;

    assign wr0 = busSel && busWrite && hit && (idx == IDX_W'(c)) && !wordSel;
    assign wr1 = busSel && busWrite && hit && (idx == IDX_W'(c)) && wordSel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        r <= '0;
      end else begin
        if (wr0) begin
          r.div <= busWdata[15:0];
          r.hi  <= busWdata[31:16];
        end
        if (wr1) begin
          r.pre <= busWdata[15:0];
          r.en  <= busWdata[31];
        end
        // A new trigger wins over an acknowledge in the same clock.
        r.updPend <= (r.updPend && !loadAck[c]) || (wr1 && busWdata[30]);
      end
    end

    assign ctl[c] = r;
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit && (idx == IDX_W'(c))) begin
        busRdata = wordSel ? {ctl[c].en, ctl[c].updPend, 14'b0, ctl[c].pre}
                           : {ctl[c].hi, ctl[c].div};
      end
    end
  end

endmodule

// File: rtl/shadow_pwm_chan.sv
module shadow_pwm_chan
  import shadow_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCtl_t ctl,
  output logic     loadAck,
  output logic     pwmOut
);

  logic [FIELD_W-1:0] actPre, actDiv, actHi;
  logic [FIELD_W-1:0] preCnt, perCnt;
  logic               stepEnd;
  logic               periodEnd;

  assign stepEnd   = (preCnt == actPre);
  assign periodEnd = stepEnd && (perCnt == actDiv);
  // Transfer at a period boundary, or at once while idle.
  assign loadAck   = ctl.updPend && (!ctl.en || periodEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPre <= '0;
      actDiv <= '0;
      actHi  <= '0;
    end else if (loadAck) begin
      actPre <= ctl.pre;
      actDiv <= ctl.div;
      actHi  <= ctl.hi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (!ctl.en) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (stepEnd) begin
      preCnt <= '0;
      perCnt <= (perCnt == actDiv) ? '0 : perCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign pwmOut = ctl.en && (perCnt <= actHi);

endmodule

// File: rtl/shadow_pwm_bank.sv
module shadow_pwm_bank
  import shadow_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busSel,
  input  logic           busWrite,
  input  logic [AW-1:0]  busAddr,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  output logic [NCH-1:0] pwmOut
);

  chanCtl_t [NCH-1:0] ctl;
  logic     [NCH-1:0] loadAck;

  shadow_pwm_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .loadAck  (loadAck),
    .ctl      (ctl)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    shadow_pwm_chan u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .ctl     (ctl[c]),
      .loadAck (loadAck[c]),
      .pwmOut  (pwmOut[c])
    );
  end

endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk
  import shadow_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [AW-1:0]      busAddr,
  input logic [31:0]        busRdata,
  input logic [NCH-1:0]     pwmOut,
  input logic [NCH-1:0]     loadAck,
  input chanCtl_t [NCH-1:0] ctl
);

  logic oob;
  logic unusedLow;

  assign oob       = int'(busAddr[AW-1:3]) >= NCH;
  assign unusedLow = ^busAddr[1:0];

  p_oob_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && oob |-> busRdata == 32'h0);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && busAddr[2] |-> busRdata[29:16] == 14'h0);

  for (genvar c = 0; c < NCH; c++) begin : g_prop
    p_clear_on_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ctl[c].updPend) |-> $past(loadAck[c]));

    p_fresh_period_r6: assert property (@(posedge clk) disable iff (!rstN)
      loadAck[c] && ctl[c].en |=> (pwmOut[c] || !ctl[c].en));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      !ctl[c].en |-> !pwmOut[c]);

    p_start_high_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ctl[c].en) |-> pwmOut[c]);
  end

endmodule

bind shadow_pwm_bank shadow_pwm_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .pwmOut   (pwmOut),
  .loadAck  (loadAck),
  .ctl      (ctl)
);

// File: tb/test_shadow_pwm_bank.sv
`timescale 1ns/1ps
module test_shadow_pwm_bank;

  localparam int NCH = 4;
  localparam int AW  = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           busSel = 1'b0;
  logic           busWrite = 1'b0;
  logic [AW-1:0]  busAddr = '0;
  logic [31:0]    busWdata = '0;
  logic [31:0]    busRdata;
  logic [NCH-1:0] pwmOut;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;

  expItem_t       expQ[$];
  logic [NCH-1:0] wave [0:511];
  logic [31:0]    pendRd;

  always #2 clk = ~clk;

  shadow_pwm_bank #(.NCH(NCH), .AW(AW)) i_shadow_pwm_bank (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pwmOut   (pwmOut)
  );

  // Driver side: queue an expected result.
  task automatic expect_(logic [31:0] v, string tag);
    expItem_t e;
    e.val = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor side: pop and compare an observed result.
  task automatic observe(logic [31:0] act);
    expItem_t e;
    nRun++;
    if (expQ.size() == 0) begin
      nFail++;
      $display("FAIL unmatched result: actual %0h expected none", act);
    end else begin
      e = expQ.pop_front();
      if (act !== e.val) begin
        nFail++;
        $display("FAIL %s: actual %0h expected %0h", e.tag, act, e.val);
      end
    end
  endtask

  task automatic wr(int ch, int word, logic [31:0] d);
    @(negedge clk);
    busSel   = 1'b1;
    busWrite = 1'b1;
    busAddr  = AW'(ch * 8 + word * 4);
    busWdata = d;
    @(negedge clk);
    busSel   = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic rdCheck(int addr, logic [31:0] exp, string tag);
    logic [31:0] d;
    expect_(exp, tag);
    @(negedge clk);
    busSel   = 1'b1;
    busWrite = 1'b0;
    busAddr  = AW'(addr);
    #1 d = busRdata;
    busSel = 1'b0;
    observe(d);
  endtask

  task automatic grab(int n);
    for (int i = 0; i < n; i++) begin
      wave[i] = pwmOut;
      @(negedge clk);
    end
  endtask

  function automatic int countHigh(int ch, int from, int n);
    int s = 0;
    for (int i = from; i < from + n; i++) s += int'(wave[i][ch]);
    return s;
  endfunction

  task automatic chk(int act, int exp, string tag);
    expect_(32'(exp), tag);
    observe(32'(act));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < NCH * 8; a += 4) rdCheck(a, 32'h0, "R1 register after reset");
    chk(int'(pwmOut), 0, "R1 outputs after reset");

    // R2: field layout and reserved bits
    wr(2, 0, 32'hABCD_1234);
    rdCheck(16, 32'hABCD_1234, "R2 word0 readback");
    wr(2, 1, 32'h3FFF_5678);
    rdCheck(20, 32'h0000_5678, "R2 reserved bits read zero");

    // R7: trigger while disabled applies next clock
    wr(0, 0, {16'd1, 16'd3});
    wr(0, 1, 32'h4000_0001);
    rdCheck(4, 32'h0000_0001, "R7 idle trigger cleared");

    // R8, R3, R4: pre=1 div=3 hi=1 -> period 8, high 4
    wr(0, 1, 32'h8000_0001);
    grab(16);
    chk(int'(wave[0][0]), 1, "R8 high in first clock");
    chk(countHigh(0, 0, 8), 4, "R4 high count first period");
    chk(int'(wave[4][0]), 0, "R4 low after high run");
    chk(int'(wave[8][0]), 1, "R3 period 8 restart");
    chk(countHigh(0, 8, 8), 4, "R3 second period");
    chk(countHigh(1, 0, 16), 0, "R10 idle channel unaffected");
    rdCheck(4, 32'h8000_0001, "R2 enable bit readback");

    // R7: disabling drives low
    wr(0, 1, 32'h0000_0001);
    grab(6);
    chk(countHigh(0, 0, 6), 0, "R7 disabled output low");

    // R4 clip on ch1, R3/R4 second pattern on ch3, R10
    wr(1, 0, {16'd9, 16'd2});
    wr(1, 1, 32'h4000_0000);
    wr(3, 0, {16'd2, 16'd4});
    wr(3, 1, 32'h4000_0002);
    wr(1, 1, 32'h8000_0000);
    wr(3, 1, 32'h8000_0002);
    grab(30);
    chk(countHigh(3, 0, 15), 9, "R4 pre2 div4 hi2 high count");
    chk(int'(wave[8][3]), 1, "R4 last high clock");
    chk(int'(wave[9][3]), 0, "R4 first low clock");
    chk(int'(wave[15][3]), 1, "R3 period 15 restart");
    chk(countHigh(1, 0, 30), 30, "R4 high clipped to full period");
    wr(1, 1, 32'h0);
    wr(3, 1, 32'h2);

    // R5, R6: update during a running period (pre0 div3 hi1 -> period 4)
    wr(0, 0, {16'd1, 16'd3});
    wr(0, 1, 32'h4000_0000);
    wr(0, 1, 32'h8000_0000);
    fork
      grab(28);
      begin
        repeat (5) @(negedge clk);
        wr(0, 0, {16'd5, 16'd7});
        wr(0, 1, 32'hC000_0000);
        busSel   = 1'b1;
        busWrite = 1'b0;
        busAddr  = AW'(4);
        #1 pendRd = busRdata;
        busSel = 1'b0;
      end
    join
    chk(int'(pendRd), 32'hC000_0000, "R5 trigger reads 1 while pending");
    chk(countHigh(0, 0, 12), 6, "R5 staged values no effect on old periods");
    chk(int'(wave[10][0]), 0, "R6 old period finishes with old high count");
    chk(int'(wave[11][0]), 0, "R6 no mid-period transfer");
    chk(countHigh(0, 12, 8), 6, "R6 new period uses new high count");
    chk(int'(wave[18][0]), 0, "R6 new period low tail");
    chk(int'(wave[20][0]), 1, "R3 new period 8 restart");
    rdCheck(4, 32'h8000_0000, "R5 trigger cleared after transfer");

    // R9: out-of-range accesses
    wr(4, 0, 32'hFFFF_FFFF);
    wr(4, 1, 32'hFFFF_FFFF);
    wr(31, 1, 32'hFFFF_FFFF);
    rdCheck(32, 32'h0, "R9 out-of-range word0 reads zero");
    rdCheck(36, 32'h0, "R9 out-of-range word1 reads zero");
    rdCheck(252, 32'h0, "R9 top index reads zero");
    rdCheck(0, 32'h0005_0007, "R9 ch0 word0 unchanged");
    rdCheck(4, 32'h8000_0000, "R9 ch0 word1 unchanged");
    rdCheck(12, 32'h0, "R9 ch1 word1 unchanged");
    grab(10);
    chk(countHigh(2, 0, 10), 0, "R9 ch2 output unchanged");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule